// File: doc/BRIEF.md
# Cross-Coverage Bin Hit Collector

This block is a synthesizable coverage monitor for fault-injection scenarios on a cache memory. It turns a small set of status flags into labelled conditions, arranged in five groups. It then forms every combination that takes exactly one condition from each group. Each combination is a bin. When every condition of a bin holds in a sampled cycle, the bin's sticky hit bit sets.

Some combinations cannot occur in hardware. A fixed set of exclusion rules names them, and each rule is a set of labels. An excluded bin keeps its place in the bin order, but its condition is tied true and it is flagged in a constant mask. As a result it reads as covered as soon as any cycle is sampled.

A registered count of covered bins lets a test environment or an on-chip monitor see closure progress at a glance.

Top module: `ccov_cross_collector`

## Requirements
- R1: The design has 24 bins. Bin index b = ((d*2 + t)*2 + s)*2 + m, with bit b of `hitVec` and `excludedMask` belonging to bin b. The digits are:
  - d: data state, none=0, correctable=1, uncorrectable=2.
  - t: tag, none=0, error=1.
  - s: source, CPU=0, bus slave port=1.
  - m: mode, scratchpad=0, cache=1.
- R2: A non-excluded bin's hit bit sets on the clock edge that samples its conditions all true, and is visible after that edge. `memActive` is a one-condition group and must be high for every such bin.
- R3: The data-none condition is true only when both `dataCorrectable` and `dataUncorrectable` are low. Correctable and uncorrectable follow their flags directly. Cache mode is the inverse of `scratchpadHit`.
- R4: A bin is excluded when it matches any of three rules:
  - tag error with scratchpad mode;
  - tag error with uncorrectable data;
  - bus slave source with cache mode.
  `excludedMask` is constant, 13 bins are excluded and 11 remain.
- R5: An excluded bin's condition is constant true. Its hit bit sets on any sampled cycle, whatever the flags.
- R6: Hit bits are sticky. Without a clear, a set bit stays set, and hits from different cycles accumulate.
- R7: While `sampleEn` is low, no hit bit changes.
- R8: `clear` zeroes all hit bits on the next edge and takes priority over a simultaneous sample.
- R9: `coveredCount` equals the population count of (`hitVec` OR `excludedMask`) as it stood one clock earlier.
- R10: During reset, `hitVec` and `coveredCount` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clear | input | 1 | Synchronous clear of all hit bits |
| sampleEn | input | 1 | Enables sampling of the flags this cycle |
| memActive | input | 1 | Memory access active |
| dataCorrectable | input | 1 | Correctable data bit error seen |
| dataUncorrectable | input | 1 | Uncorrectable data bit error seen |
| tagError | input | 1 | Tag bit error seen |
| fromSlave | input | 1 | Request came from the bus slave port (low means CPU) |
| scratchpadHit | input | 1 | Access targets scratchpad mode (low means cache mode) |
| hitVec | output | 24 | Sticky hit bit per bin |
| excludedMask | output | 24 | Constant flag per excluded bin |
| coveredCount | output | 5 | Registered count of hit or excluded bins |

## Verification
The assertions treat the flags as free inputs: any combination may appear, including both data error flags high at once. They only require that `clear` and `sampleEn` are sampled at a clock edge.

The stimulus sweeps all 64 flag patterns, each after a clear, so every pattern is checked in isolation. It also runs one back-to-back accumulation pass, a sample held off by a low enable, and a cycle where clear and sample are both high. All inputs change on the falling edge, so they are never ambiguous at a sampling edge.

// File: rtl/ccov_pkg.sv
package ccov_pkg;

  localparam int NUM_GROUPS = 5;
  localparam int GROUP_SIZE [NUM_GROUPS] = '{1, 3, 2, 2, 2};
  localparam int NUM_EXCL = 3;

  function automatic int totalConds();
    int s = 0;
    for (int g = 0; g < NUM_GROUPS; g++) s += GROUP_SIZE[g];
    return s;
  endfunction

  function automatic int totalBins();
    int p = 1;
    for (int g = 0; g < NUM_GROUPS; g++) p *= GROUP_SIZE[g];
    return p;
  endfunction

  localparam int NUM_CONDS = totalConds();
  localparam int NUM_BINS  = totalBins();
  localparam int CNT_W     = $clog2(NUM_BINS + 1);

  // flat condition label positions, group by group
  localparam int L_MEM    = 0;
  localparam int L_DNONE  = 1;
  localparam int L_DCORR  = 2;
  localparam int L_DUNC   = 3;
  localparam int L_TNONE  = 4;
  localparam int L_TERR   = 5;
  localparam int L_SCPU   = 6;
  localparam int L_SSLV   = 7;
  localparam int L_MSCR   = 8;
  localparam int L_MCACHE = 9;

  // each exclusion rule is a label set; subset match excludes the bin
  localparam logic [NUM_CONDS-1:0] EXCL_SET [NUM_EXCL] = '{
    NUM_CONDS'((1 << L_TERR) | (1 << L_MSCR)),
    NUM_CONDS'((1 << L_TERR) | (1 << L_DUNC)),
    NUM_CONDS'((1 << L_SSLV) | (1 << L_MCACHE))
  };

  typedef struct packed {
    logic sample;
    logic clear;
  } ccovStrobe_t;

  function automatic int condOffset(int g);
    int s = 0;
    for (int k = 0; k < g; k++) s += GROUP_SIZE[k];
    return s;
  endfunction

  // last group varies fastest
  function automatic int binStride(int g);
    int p = 1;
    for (int k = g + 1; k < NUM_GROUPS; k++) p *= GROUP_SIZE[k];
    return p;
  endfunction

  function automatic logic [NUM_CONDS-1:0] binLabels(int b);
    logic [NUM_CONDS-1:0] lbl = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      lbl[condOffset(g) + (b / binStride(g)) % GROUP_SIZE[g]] = 1'b1;
    return lbl;
  endfunction

  function automatic logic binExcluded(int b);
    logic [NUM_CONDS-1:0] lbl = binLabels(b);
    logic ex = 1'b0;
    for (int e = 0; e < NUM_EXCL; e++)
      if ((EXCL_SET[e] & ~lbl) == '0) ex = 1'b1;
    return ex;
  endfunction

endpackage

// File: rtl/ccov_cond_map.sv
module ccov_cond_map
  import ccov_pkg::*;
(
  input  logic                 memActive,
  input  logic                 dataCorrectable,
  input  logic                 dataUncorrectable,
  input  logic                 tagError,
  input  logic                 fromSlave,
  input  logic                 scratchpadHit,
  output logic [NUM_CONDS-1:0] conds
);
  always_comb begin
    conds           = '0;
    conds[L_MEM]    = memActive;
    conds[L_DNONE]  = ~dataCorrectable & ~dataUncorrectable;
    conds[L_DCORR]  = dataCorrectable;
    conds[L_DUNC]   = dataUncorrectable;
    conds[L_TNONE]  = ~tagError;
    conds[L_TERR]   = tagError;
    conds[L_SCPU]   = ~fromSlave;
    conds[L_SSLV]   = fromSlave;
    conds[L_MSCR]   = scratchpadHit;
    conds[L_MCACHE] = ~scratchpadHit;
  end
endmodule

// File: rtl/ccov_ctrl.sv
module ccov_ctrl
  import ccov_pkg::*;
(
  input  logic        clear,
  input  logic        sampleEn,
  output ccovStrobe_t strobe
);
  // clear wins over sampling in the same cycle
  always_comb begin
    strobe.clear  = clear;
    strobe.sample = sampleEn & ~clear;
  end
endmodule

// File: rtl/ccov_bins.sv
module ccov_bins
  import ccov_pkg::*;
#(
  parameter int BINS  = NUM_BINS,
  parameter int CONDS = NUM_CONDS,
  parameter int CW    = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ccovStrobe_t      strobe,
  input  logic [CONDS-1:0] conds,
  output logic [BINS-1:0]  hitVec,
  output logic [BINS-1:0]  excludedMask,
  output logic [CW-1:0]    coveredCount
);
  logic [BINS-1:0] binCond;
  logic [BINS-1:0] hitQ;
  logic [CW-1:0]   countQ;
  logic [CW-1:0]   coveredNext;

  for (genvar b = 0; b < BINS; b++) begin : g_bin
    localparam logic [CONDS-1:0] LBL  = CONDS'(binLabels(b));
    localparam logic             EXCL = binExcluded(b);
    if (EXCL) begin : g_excl
      assign binCond[b] = 1'b1;
    end else begin : g_live
      assign binCond[b] = &(conds | ~LBL);
    end
    assign excludedMask[b] = EXCL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            hitQ <= '0;
    else if (strobe.clear) hitQ <= '0;
    else if (strobe.sample) hitQ <= hitQ | binCond;
  end

  always_comb begin
    coveredNext = '0;
    for (int i = 0; i < BINS; i++)
      coveredNext = coveredNext + CW'(hitQ[i] | excludedMask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) countQ <= '0;
    else        countQ <= coveredNext;
  end

  assign hitVec       = hitQ;
  assign coveredCount = countQ;
endmodule

// File: rtl/ccov_cross_collector.sv
module ccov_cross_collector
  import ccov_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                sampleEn,
  input  logic                memActive,
  input  logic                dataCorrectable,
  input  logic                dataUncorrectable,
  input  logic                tagError,
  input  logic                fromSlave,
  input  logic                scratchpadHit,
  output logic [NUM_BINS-1:0] hitVec,
  output logic [NUM_BINS-1:0] excludedMask,
  output logic [CNT_W-1:0]    coveredCount
);
  logic [NUM_CONDS-1:0] conds;
  ccovStrobe_t          strobe;

  ccov_cond_map u_map (
    .memActive(memActive), .dataCorrectable(dataCorrectable),
    .dataUncorrectable(dataUncorrectable), .tagError(tagError),
    .fromSlave(fromSlave), .scratchpadHit(scratchpadHit), .conds(conds)
  );

  ccov_ctrl u_ctrl (.clear(clear), .sampleEn(sampleEn), .strobe(strobe));

  ccov_bins u_bins (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .conds(conds),
    .hitVec(hitVec), .excludedMask(excludedMask), .coveredCount(coveredCount)
  );
endmodule

// File: rtl/ccov_checker.sv
module ccov_checker
  import ccov_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                clear,
  input logic                sampleEn,
  input logic                memActive,
  input logic                dataCorrectable,
  input logic                dataUncorrectable,
  input logic                tagError,
  input logic                fromSlave,
  input logic                scratchpadHit,
  input logic [NUM_BINS-1:0] hitVec,
  input logic [NUM_BINS-1:0] excludedMask,
  input logic [CNT_W-1:0]    coveredCount
);
  p_bin0_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleEn && !clear && memActive && !dataCorrectable && !dataUncorrectable
     && !tagError && !fromSlave && scratchpadHit) |=> hitVec[0]);

  p_excl_covered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleEn && !clear) |=> ((hitVec & excludedMask) == excludedMask));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((hitVec & $past(hitVec)) == $past(hitVec)));

  p_hold_no_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleEn && !clear) |=> $stable(hitVec));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (hitVec == '0));

  p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (32'(coveredCount) == $countones($past(hitVec | excludedMask))));

  p_mask_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(excludedMask) == 13);
endmodule

bind ccov_cross_collector ccov_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .sampleEn(sampleEn),
  .memActive(memActive), .dataCorrectable(dataCorrectable),
  .dataUncorrectable(dataUncorrectable), .tagError(tagError),
  .fromSlave(fromSlave), .scratchpadHit(scratchpadHit),
  .hitVec(hitVec), .excludedMask(excludedMask), .coveredCount(coveredCount)
);

// File: tb/sim_ccov_cross_collector.sv
`timescale 1ns/1ps
module sim_ccov_cross_collector;
  logic clk = 1'b0;
  logic rst_n, clear, sampleEn;
  logic memActive, dataCorrectable, dataUncorrectable, tagError, fromSlave, scratchpadHit;
  logic [23:0] hitVec, excludedMask;
  logic [4:0]  coveredCount;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ccov_cross_collector u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sampleEn(sampleEn),
    .memActive(memActive), .dataCorrectable(dataCorrectable),
    .dataUncorrectable(dataUncorrectable), .tagError(tagError),
    .fromSlave(fromSlave), .scratchpadHit(scratchpadHit),
    .hitVec(hitVec), .excludedMask(excludedMask), .coveredCount(coveredCount)
  );

  function automatic logic expExcl(int b);
    int d = b / 8, t = (b / 4) % 2, s = (b / 2) % 2, m = b % 2;
    return (t == 1 && m == 0) || (t == 1 && d == 2) || (s == 1 && m == 1);
  endfunction

  function automatic logic [23:0] expMask();
    logic [23:0] v;
    for (int b = 0; b < 24; b++) v[b] = expExcl(b);
    return v;
  endfunction

  // pat bits: 5 mem, 4 corr, 3 uncorr, 2 tag, 1 slave, 0 scratch
  function automatic logic [23:0] expBins(logic [5:0] p);
    logic [23:0] v;
    for (int b = 0; b < 24; b++) begin
      int d = b / 8, t = (b / 4) % 2, s = (b / 2) % 2, m = b % 2;
      logic dc;
      dc = (d == 0) ? (!p[4] && !p[3]) : (d == 1) ? p[4] : p[3];
      v[b] = expExcl(b) ||
             (p[5] && dc && (p[2] == t[0]) && (p[1] == s[0]) && (p[0] == !m[0]));
    end
    return v;
  endfunction

  function automatic int pop(logic [23:0] v);
    int n = 0;
    for (int i = 0; i < 24; i++) n += v[i];
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setPat(logic [5:0] p);
    memActive = p[5]; dataCorrectable = p[4]; dataUncorrectable = p[3];
    tagError = p[2]; fromSlave = p[1]; scratchpadHit = p[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] acc;
    rst_n = 0; clear = 0; sampleEn = 0; setPat(6'b0);
    repeat (3) @(negedge clk);
    chk("R10 hit", int'(hitVec), 0);
    chk("R10 count", int'(coveredCount), 0);
    chk("R4 mask", int'(excludedMask), int'(expMask()));
    chk("R4 count13", pop(excludedMask), 13);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle count", int'(coveredCount), 13);
    // R7: enable low must not record
    setPat(6'b100001);
    repeat (2) @(negedge clk);
    chk("R7 no sample", int'(hitVec), 0);
    // R1 R2 R3 R5: each pattern in isolation
    for (int p = 0; p < 64; p++) begin
      clear = 1; sampleEn = 0;
      @(negedge clk);
      clear = 0;
      chk("R8 cleared", int'(hitVec), 0);
      setPat(6'(p)); sampleEn = 1;
      @(negedge clk);
      sampleEn = 0;
      chk("R2 R1 R3 hit", int'(hitVec), int'(expBins(6'(p))));
      @(negedge clk);
      chk("R9 count", int'(coveredCount), pop(expBins(6'(p))));
      if (p == 0) chk("R5 excl only", int'(hitVec), int'(expMask()));
    end
    // R6: accumulate all patterns
    clear = 1; @(negedge clk); clear = 0;
    acc = '0;
    for (int p = 0; p < 64; p++) begin
      setPat(6'(p)); sampleEn = 1; acc |= expBins(6'(p));
      @(negedge clk);
    end
    sampleEn = 0;
    chk("R6 sticky", int'(hitVec), int'(acc));
    @(negedge clk);
    chk("R9 full count", int'(coveredCount), 24);
    // R8: clear beats sample
    setPat(6'b100001); clear = 1; sampleEn = 1;
    @(negedge clk);
    clear = 0; sampleEn = 0;
    chk("R8 priority", int'(hitVec), 0);
    @(negedge clk);
    chk("R9 after clear", int'(coveredCount), 13);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule